// File: doc/BRIEF.md
# Firmware/Application Mode Register Bank

This block is a small memory-mapped register bank that sits between the CPU bus and the board-level pins. It is the single point where boot firmware hands control to a loaded application. It holds a one-way execution-mode flag. The flag comes out of reset in firmware mode, and a single write moves it to application mode. It stays there until the next reset.

Firmware uses the bank to publish the start address and byte size of the application it loaded. It then writes the mode register. From that point the application can read those values but cannot change them, and it cannot leave application mode. Both modes may use the LED control register and the general-purpose outputs. Both modes may also read two constant identification words, a version number, and two input pins that are brought into the clock domain.

The bus is a plain select / write-enable / word-address / data interface. A write takes effect on the clock edge where `cs_i` and `we_i` are both high. Read data is combinational while `cs_i` is high and `we_i` is low. Word addresses with any bit at or above bit 4 set are unmapped.

Top module: `xmr_regbank`

## Requirements
- R1: After reset, `app_mode_o` is 0 (firmware mode), `led_o` and `gpio_out_o` are all zero, and the LED, GPIO-output, start-address and size registers read back as zero.
- R2: Reads of word 0 return bits 63:32 of the 64-bit ASCII design name, reads of word 1 return bits 31:0, and reads of word 2 return the 32-bit design version. Writes to these words change nothing.
- R3: Word 4 is the LED register. Bit 0 drives `led_o[0]` (blue), bit 1 drives `led_o[1]` (green) and bit 2 drives `led_o[2]` (red), with 1 meaning on. The register reads back its value in bits 2:0, and its upper bits read as zero.
- R4: In word 5, bits 1:0 return `gpio_in_i[1:0]` (pins 1 and 2) after a two-flop synchroniser. A pin change becomes visible after the second rising edge and not after the first.
- R5: Bits 3:2 of word 5 are output bits. A write drives them onto `gpio_out_o[1:0]` (pins 3 and 4) and they read back in the same positions. Writes to bits 1:0 of word 5 have no effect.
- R6: In firmware mode, word 6 (application start address) and word 7 (application size) store the full 32-bit write data, and both modes can read them.
- R7: In firmware mode, any write to word 8 sets `app_mode_o` to 1 from the following cycle. Word 8 then reads as 1 in bit 0, where firmware mode reads 0.
- R8: In application mode, writes to words 6, 7 and 8 are ignored, and `app_mode_o` stays 1 until reset.
- R9: The LED register and GPIO output bits stay writable in application mode.
- R10: Reads of unmapped addresses, and any read while `cs_i` is low, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write enable (with `cs_i`) |
| addr_i | input | ADDR_W (8) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| led_o | output | LED_W (3) | LED enables: 0 blue, 1 green, 2 red |
| gpio_in_i | input | GPIO_IN_N (2) | Asynchronous input pins 1 and 2 |
| gpio_out_o | output | GPIO_OUT_N (2) | Output pins 3 and 4 |
| app_mode_o | output | 1 | 1 once application mode is entered |

## Verification
The bench goes after the mode lock. After the mode write it repeatedly writes the start address, size and mode words with random data. A design that gated the lock on the wrong flag, or only on some of these words, would show changed read-back values, or would let `app_mode_o` fall back to 0. It checks the synchroniser latency one edge at a time: a single-flop design would show the new pin value one cycle early, and a design with an extra stage would show it one cycle late. It also writes ones into the GPIO input bits and the unused LED bits, and reads unmapped and out-of-range addresses. A misplaced field or a partial address decode would show up as stray read data.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

  localparam int unsigned IDX_W  = 4;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [IDX_W-1:0] {
    IDX_NAME_HI  = 4'd0,
    IDX_NAME_LO  = 4'd1,
    IDX_VERSION  = 4'd2,
    IDX_LED      = 4'd4,
    IDX_GPIO     = 4'd5,
    IDX_APP_ADDR = 4'd6,
    IDX_APP_SIZE = 4'd7,
    IDX_MODE     = 4'd8
  } reg_idx_e;

  typedef struct packed {
    logic name_hi;
    logic name_lo;
    logic version;
    logic led;
    logic gpio;
    logic app_addr;
    logic app_size;
    logic mode;
  } reg_hit_t;

endpackage

// File: rtl/xmr_sync.sv
module xmr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  generate
    if (STAGES >= 2) begin : g_chk
      // R4: the last stage copies the one before it, one edge later
      a_r4_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
    end
  endgenerate

endmodule

// File: rtl/xmr_decode.sv
module xmr_decode
  import xmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_hit_t          hit_o
);

  localparam int unsigned HI_W = ADDR_W - IDX_W;

  logic in_range;

  generate
    if (HI_W > 0) begin : g_hi
      assign in_range = (addr_i[ADDR_W-1:IDX_W] == '0);
    end else begin : g_nohi
      assign in_range = 1'b1;
    end
  endgenerate

  always_comb begin
    hit_o = '0;
    if (in_range) begin
      case (addr_i[IDX_W-1:0])
        IDX_NAME_HI:  hit_o.name_hi  = 1'b1;
        IDX_NAME_LO:  hit_o.name_lo  = 1'b1;
        IDX_VERSION:  hit_o.version  = 1'b1;
        IDX_LED:      hit_o.led      = 1'b1;
        IDX_GPIO:     hit_o.gpio     = 1'b1;
        IDX_APP_ADDR: hit_o.app_addr = 1'b1;
        IDX_APP_SIZE: hit_o.app_size = 1'b1;
        IDX_MODE:     hit_o.mode     = 1'b1;
        default:      hit_o          = '0;
      endcase
    end
  end

endmodule

// File: rtl/xmr_mode_ctl.sv
module xmr_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr_i,
  output logic app_mode_o
);

  logic app_q;
  logic app_d;
  logic app_en;

  // one-way: only a firmware-mode write may move the flag
  always_comb begin
    app_en = mode_wr_i & ~app_q;
    app_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      app_q <= 1'b0;
    else if (app_en) app_q <= app_d;
  end

  assign app_mode_o = app_q;

  // R8: application mode holds until reset
  a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    app_q |=> app_q);

  // R7: a mode write in firmware mode enters application mode next cycle
  a_r7_mode_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && !app_q) |=> app_q);

endmodule

// File: rtl/xmr_regs.sv
module xmr_regs
  import xmr_pkg::*;
#(
  parameter int unsigned LED_W      = 3,
  parameter int unsigned GPIO_IN_N  = 2,
  parameter int unsigned GPIO_OUT_N = 2,
  parameter logic [63:0] NAME       = 64'h0,
  parameter logic [31:0] VERSION    = 32'h0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en_i,
  input  logic                  wr_en_i,
  input  reg_hit_t              hit_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  app_mode_i,
  input  logic [GPIO_IN_N-1:0]  gpi_sync_i,
  output logic [LED_W-1:0]      led_o,
  output logic [GPIO_OUT_N-1:0] gpo_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam int unsigned GPIO_W = GPIO_IN_N + GPIO_OUT_N;

  logic [LED_W-1:0]      led_q,  led_d;
  logic [GPIO_OUT_N-1:0] gpo_q,  gpo_d;
  logic [DATA_W-1:0]     addr_q, addr_d;
  logic [DATA_W-1:0]     size_q, size_d;
  logic led_en, gpo_en, addr_en, size_en;

  // next-state and enables
  always_comb begin
    led_en  = wr_en_i & hit_i.led;
    gpo_en  = wr_en_i & hit_i.gpio;
    addr_en = wr_en_i & hit_i.app_addr & ~app_mode_i;
    size_en = wr_en_i & hit_i.app_size & ~app_mode_i;
    led_d   = wdata_i[LED_W-1:0];
    gpo_d   = wdata_i[GPIO_IN_N +: GPIO_OUT_N];
    addr_d  = wdata_i;
    size_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      gpo_q  <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else begin
      if (led_en)  led_q  <= led_d;
      if (gpo_en)  gpo_q  <= gpo_d;
      if (addr_en) addr_q <= addr_d;
      if (size_en) size_q <= size_d;
    end
  end

  // read multiplexer
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit_i.name_hi)  rdata_o = NAME[63:32];
      if (hit_i.name_lo)  rdata_o = NAME[31:0];
      if (hit_i.version)  rdata_o = VERSION;
      if (hit_i.led)      rdata_o[LED_W-1:0] = led_q;
      if (hit_i.gpio)     rdata_o[GPIO_W-1:0] = {gpo_q, gpi_sync_i};
      if (hit_i.app_addr) rdata_o = addr_q;
      if (hit_i.app_size) rdata_o = size_q;
      if (hit_i.mode)     rdata_o[0] = app_mode_i;
    end
  end

  assign led_o = led_q;
  assign gpo_o = gpo_q;

  // R8: start address and size frozen in application mode
  a_r8_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode_i |=> $stable(addr_q));
  a_r8_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode_i |=> $stable(size_q));

  // R3: LED register changes only through a write to its word
  a_r3_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && hit_i.led) |=> $stable(led_q));

  // R5: output pins change only through a write to the GPIO word
  a_r5_gpo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && hit_i.gpio) |=> $stable(gpo_q));

endmodule

// File: rtl/xmr_regbank.sv
module xmr_regbank
  import xmr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LED_W      = 3,
  parameter int unsigned GPIO_IN_N  = 2,
  parameter int unsigned GPIO_OUT_N = 2,
  parameter int unsigned SYNC_STG   = 2,
  parameter logic [63:0] NAME       = 64'h786d_7262_616e_6b31,
  parameter logic [31:0] VERSION    = 32'd3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [LED_W-1:0]      led_o,
  input  logic [GPIO_IN_N-1:0]  gpio_in_i,
  output logic [GPIO_OUT_N-1:0] gpio_out_o,
  output logic                  app_mode_o
);

  reg_hit_t              hit;
  logic                  wr_en;
  logic                  rd_en;
  logic                  app_mode;
  logic [GPIO_IN_N-1:0]  gpi_sync;

  assign wr_en = cs_i & we_i;
  assign rd_en = cs_i & ~we_i;

  xmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  xmr_sync #(.WIDTH(GPIO_IN_N), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (gpio_in_i),
    .sync_o  (gpi_sync)
  );

  xmr_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr_i  (wr_en & hit.mode),
    .app_mode_o (app_mode)
  );

  xmr_regs #(
    .LED_W      (LED_W),
    .GPIO_IN_N  (GPIO_IN_N),
    .GPIO_OUT_N (GPIO_OUT_N),
    .NAME       (NAME),
    .VERSION    (VERSION)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en),
    .wr_en_i    (wr_en),
    .hit_i      (hit),
    .wdata_i    (wdata_i),
    .app_mode_i (app_mode),
    .gpi_sync_i (gpi_sync),
    .led_o      (led_o),
    .gpo_o      (gpio_out_o),
    .rdata_o    (rdata_o)
  );

  assign app_mode_o = app_mode;

  // R10: nothing is returned while deselected
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> (rdata_o == '0));

endmodule

// File: tb/xmr_regbank_bench.sv
module xmr_regbank_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] NAME_C = 64'h786d_7262_616e_6b31;
  localparam logic [31:0] VER_C  = 32'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  led;
  logic [1:0]  gpi = '0;
  logic [1:0]  gpo;
  logic        app_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench-side model
  logic [2:0]  m_led;
  logic [1:0]  m_gpo;
  logic [31:0] m_addr, m_size;
  logic        m_app;
  logic [1:0]  m_gpi;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmr_regbank u_xmr_regbank (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .led_o(led), .gpio_in_i(gpi),
    .gpio_out_o(gpo), .app_mode_o(app_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a[7:4] != 4'd0) return 32'h0;
    case (a[3:0])
      4'd0: return NAME_C[63:32];
      4'd1: return NAME_C[31:0];
      4'd2: return VER_C;
      4'd4: return {29'd0, m_led};
      4'd5: return {28'd0, m_gpo, m_gpi};
      4'd6: return m_addr;
      4'd7: return m_size;
      4'd8: return {31'd0, m_app};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a[7:4] != 4'd0) return "R10";
    case (a[3:0])
      4'd0, 4'd1, 4'd2: return "R2";
      4'd4: return "R3";
      4'd5: return "R5";
      4'd6, 4'd7: return m_app ? "R8" : "R6";
      4'd8: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a[7:4] == 4'd0) begin
      case (a[3:0])
        4'd4: m_led = d[2:0];
        4'd5: m_gpo = d[3:2];
        4'd6: if (!m_app) m_addr = d;
        4'd7: if (!m_app) m_size = d;
        4'd8: m_app = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    cs = 1'b0;
  endtask

  task automatic read_check(input logic [7:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check(tag_of(a), d, exp_read(a));
  endtask

  task automatic check_pins();
    check("R3 led_o", {29'd0, led}, {29'd0, m_led});
    check("R5 gpio_out_o", {30'd0, gpo}, {30'd0, m_gpo});
    check(m_app ? "R8 app_mode_o" : "R7 app_mode_o", {31'd0, app_mode}, {31'd0, m_app});
  endtask

  task automatic random_phase(input int n, input bit allow_mode);
    for (int i = 0; i < n; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = {4'd0, 4'($urandom % 16)};
      if (($urandom % 8) == 0) a[7:4] = 4'($urandom % 15 + 1);
      if (!allow_mode && a == 8'd8) a = 8'd6;
      d = $urandom;
      if ($urandom % 2) bus_write(a, d);
      else read_check(a);
      check_pins();
    end
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1357_2468));
    m_led = '0; m_gpo = '0; m_addr = '0; m_size = '0; m_app = 1'b0; m_gpi = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 app_mode_o", {31'd0, app_mode}, 32'd0);
    check("R1 led_o", {29'd0, led}, 32'd0);
    check("R1 gpio_out_o", {30'd0, gpo}, 32'd0);
    for (int k = 4; k <= 8; k++) begin
      bus_read(8'(k), d);
      check("R1 readback", d, 32'd0);
    end

    // R10 deselected reads zero
    addr = 8'd2; #1 check("R10 cs low", rdata, 32'd0);

    // R2 identification and write immunity
    read_check(8'd0); read_check(8'd1); read_check(8'd2);
    bus_write(8'd2, 32'hFFFF_FFFF); bus_write(8'd0, 32'h0);
    bus_read(8'd2, d); check("R2 version after write", d, VER_C);
    bus_read(8'd0, d); check("R2 name after write", d, NAME_C[63:32]);

    // R3 LED bit mapping
    bus_write(8'd4, 32'h0000_0001); check("R3 blue", {29'd0, led}, 32'd1);
    bus_write(8'd4, 32'h0000_0002); check("R3 green", {29'd0, led}, 32'd2);
    bus_write(8'd4, 32'hFFFF_FFFC); check("R3 red", {29'd0, led}, 32'd4);
    read_check(8'd4);

    // R4 synchroniser latency
    @(negedge clk); gpi = 2'b10;
    @(negedge clk); addr = 8'd5; cs = 1'b1; #1
    check("R4 after one edge", rdata & 32'h3, 32'd0);
    @(negedge clk); #1
    check("R4 after two edges", rdata & 32'h3, 32'd2);
    cs = 1'b0; m_gpi = 2'b10;

    // R5 outputs, input bits not writable
    bus_write(8'd5, 32'h0000_0007);
    check("R5 gpio_out_o", {30'd0, gpo}, 32'd1);
    read_check(8'd5);
    bus_write(8'd5, 32'h0000_000B);
    check("R5 gpio_out_o", {30'd0, gpo}, 32'd2);
    read_check(8'd5);

    // R6 start address and size
    bus_write(8'd6, 32'h0002_0000); bus_write(8'd7, 32'h0000_1F40);
    read_check(8'd6); read_check(8'd7);

    // R10 out-of-range alias and hole
    read_check(8'h16); read_check(8'd3); read_check(8'd15);

    random_phase(300, 1'b0);

    // R7 mode entry
    bus_read(8'd8, d); check("R7 mode reads 0 in firmware", d, 32'd0);
    bus_write(8'd8, 32'h0);
    check("R7 app_mode_o set", {31'd0, app_mode}, 32'd1);
    bus_read(8'd8, d); check("R7 mode reads 1", d, 32'd1);

    // R8 lock
    bus_write(8'd6, 32'hDEAD_BEEF); bus_write(8'd7, 32'h1234_5678);
    bus_write(8'd8, 32'h0);
    read_check(8'd6); read_check(8'd7);
    check("R8 still app", {31'd0, app_mode}, 32'd1);

    // R9 LED/GPIO still writable
    bus_write(8'd4, 32'h5); check("R9 led_o", {29'd0, led}, 32'd5);
    bus_write(8'd5, 32'hC); check("R9 gpio_out_o", {30'd0, gpo}, 32'd3);

    random_phase(300, 1'b1);

    // R1 reset returns to firmware mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_led = '0; m_gpo = '0; m_addr = '0; m_size = '0; m_app = 1'b0; m_gpi = '0;
    check("R1 mode after reset", {31'd0, app_mode}, 32'd0);
    check("R1 led after reset", {29'd0, led}, 32'd0);
    @(negedge clk); m_gpi = gpi;
    bus_write(8'd6, 32'hA5A5_0001); read_check(8'd6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule